// File: doc/BRIEF.md
# PLL Control and Lock Monitor

This block is the register-side controller for an on-chip clock generator. A small write/read port reaches two 8-bit registers. One holds the system clock source request and the lock-criteria code. The other holds the PLL enable bit, two interrupt enables, two sticky interrupt flags and a read-only lock status bit. The lock criteria are only held and passed on, because the lock detector that would use them is outside this block.

A raw lock indication from the PLL passes through a synchronizer into the system clock domain. Edges on the synchronized signal set the lock and unlock flags. Any flag whose enable is set raises the single interrupt output. The block also drives the select code for the system clock multiplexer. It refuses a PLL selection that could not run, and it returns to the crystal if an active PLL selection loses lock or is disabled.

Top module: `pllctl_top`

## Requirements
- R1: After reset, register 0 and register 1 both read 0x00, `clk_sel` is 00 and `irq` is 0.
- R2: Register 0 bits [3:2] hold the lock-criteria code (00: 8 cycles of 20 ns, 01: 16 cycles of 20 ns, 10: 8 cycles of 400 ns, 11: 16 cycles of 400 ns). A write updates them only while the enable (register 1 bit 0) is 0. Otherwise the write leaves them unchanged.
- R3: Register 0 bits [1:0] request the source (00 crystal, 01 PLL, 10 RTC crystal, 11 reserved). Writing 11 leaves `clk_sel` unchanged.
- R4: Writing the PLL code 01 takes effect only if the PLL is enabled and the synchronized lock is 1. Otherwise the previous source stays.
- R5: Register 1 bit 5 shows the raw lock input after two register stages. It changes on the second rising clock edge after the input changes.
- R6: A rising edge of the synchronized lock sets the lock flag (register 1 bit 3). A falling edge sets the unlock flag (register 1 bit 4).
- R7: Writing 1 to bit 3 or bit 4 of register 1 clears that flag. An edge that arrives in the same cycle as the clear wins, and the flag stays 1.
- R8: `irq` is 1 exactly when the lock flag is set with its enable (bit 1) set, or when the unlock flag is set with its enable (bit 2) set.
- R9: While `clk_sel` is 01, losing the synchronized lock or clearing the enable bit switches `clk_sel` to 00 one cycle later.
- R10: Source codes 00 and 10 are accepted while the PLL is enabled, and `clk_sel` follows one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 source/criteria, 1 control/status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| lock_raw | input | 1 | Asynchronous lock indication from the PLL |
| clk_sel | output | 2 | Select code for the system clock multiplexer |
| irq | output | 1 | Combined lock/unlock interrupt |

## Verification
The hardest case to reach from the ports is a clear of a flag that lands in the same cycle a new edge sets it. The bench first sets the lock flag and drops the lock so that the flag remains set. It then raises the lock input on a falling clock edge and counts two rising edges through the synchronizer. The write-one-to-clear is issued so that it is captured on the third edge, the one on which the detector fires. The PLL fallback case needs a similar sequence: the PLL must first be enabled, then lock, and only then be selected before the lock is dropped.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

    localparam int REG_W      = 8;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_PLL  = 2'b01,
        SRC_RTC  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    // register 1 bit positions
    localparam int B_EN     = 0;
    localparam int B_LIE    = 1;
    localparam int B_UIE    = 2;
    localparam int B_LFLAG  = 3;
    localparam int B_UFLAG  = 4;
    localparam int B_STATUS = 5;

    typedef struct packed {
        logic       en;
        logic       lock_ie;
        logic       unlock_ie;
    } ctrl_s;

    typedef struct packed {
        logic       lock_flag;
        logic       unlock_flag;
    } flags_s;

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_s c, flags_s f, logic status);
        logic [REG_W-1:0] v;
        v           = '0;
        v[B_EN]     = c.en;
        v[B_LIE]    = c.lock_ie;
        v[B_UIE]    = c.unlock_ie;
        v[B_LFLAG]  = f.lock_flag;
        v[B_UFLAG]  = f.unlock_flag;
        v[B_STATUS] = status;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(logic [1:0] crit, src_e src);
        logic [REG_W-1:0] v;
        v      = '0;
        v[1:0] = src;
        v[3:2] = crit;
        return v;
    endfunction

endpackage

// File: rtl/pllctl_sync.sv
module pllctl_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic dout_prev
);
    logic [DEPTH:0] stage;

    for (genvar i = 0; i <= DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= 1'b0;
                else     stage[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= 1'b0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign dout      = stage[DEPTH-1];
    assign dout_prev = stage[DEPTH];
endmodule

// File: rtl/pllctl_flags.sv
module pllctl_flags
    import pllctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lock_s,
    input  logic   lock_s_prev,
    input  logic   clr_lock,
    input  logic   clr_unlock,
    input  ctrl_s  ctrl,
    output flags_s flags,
    output logic   irq
);
    logic rise, fall;

    assign rise = lock_s & ~lock_s_prev;
    assign fall = ~lock_s & lock_s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.lock_flag   <= (flags.lock_flag   & ~clr_lock)   | rise;
            flags.unlock_flag <= (flags.unlock_flag & ~clr_unlock) | fall;
        end
    end

    assign irq = (flags.lock_flag & ctrl.lock_ie) | (flags.unlock_flag & ctrl.unlock_ie);
endmodule

// File: rtl/pllctl_clksel.sv
module pllctl_clksel
    import pllctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_src,
    input  logic [1:0] src_req,
    input  logic       pll_en,
    input  logic       locked,
    output src_e       sel
);
    logic pll_ok;
    src_e sel_nxt;

    assign pll_ok = pll_en & locked;

    always_comb begin
        sel_nxt = sel;
        if (sel == SRC_PLL && !pll_ok) sel_nxt = SRC_XTAL;
        if (wr_src) begin
            case (src_e'(src_req))
                SRC_RSVD: ;
                SRC_PLL:  if (pll_ok) sel_nxt = SRC_PLL;
                default:  sel_nxt = src_e'(src_req);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel <= SRC_XTAL;
        else     sel <= sel_nxt;
    end
endmodule

// File: rtl/pllctl_top.sv
module pllctl_top
    import pllctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             lock_raw,
    output logic [1:0]       clk_sel,
    output logic             irq
);
    ctrl_s      ctrl;
    flags_s     flags;
    logic [1:0] crit;
    logic       lock_sync, lock_prev;
    logic       wr_cfg, wr_ctl;
    src_e       sel;

    assign wr_cfg = wr_en & ~addr;
    assign wr_ctl = wr_en &  addr;

    pllctl_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .din(lock_raw),
        .dout(lock_sync), .dout_prev(lock_prev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            crit <= 2'b00;
        end else begin
            if (wr_ctl) begin
                ctrl.en        <= wdata[B_EN];
                ctrl.lock_ie   <= wdata[B_LIE];
                ctrl.unlock_ie <= wdata[B_UIE];
            end
            if (wr_cfg && !ctrl.en) crit <= wdata[3:2];
        end
    end

    pllctl_flags u_flags (
        .clk(clk), .rst(rst),
        .lock_s(lock_sync), .lock_s_prev(lock_prev),
        .clr_lock(wr_ctl & wdata[B_LFLAG]),
        .clr_unlock(wr_ctl & wdata[B_UFLAG]),
        .ctrl(ctrl), .flags(flags), .irq(irq)
    );

    pllctl_clksel u_sel (
        .clk(clk), .rst(rst),
        .wr_src(wr_cfg), .src_req(wdata[1:0]),
        .pll_en(ctrl.en), .locked(lock_sync),
        .sel(sel)
    );

    assign clk_sel = sel;
    assign rdata   = addr ? pack_ctrl(ctrl, flags, lock_sync) : pack_cfg(crit, sel);
endmodule

// File: rtl/pllctl_chk.sv
module pllctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [1:0] clk_sel,
    input logic [1:0] crit,
    input logic       lock_sync,
    input logic       pll_on,
    input logic       lflag
);
    // R2
    crit_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && pll_on) |=> $stable(crit));

    // R3
    rsvd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[1:0] == 2'b11 && !(clk_sel == 2'b01 && !(pll_on && lock_sync)))
        |=> $stable(clk_sel));

    // R4
    pll_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 2'b01 && $past(clk_sel) != 2'b01) |-> $past(pll_on && lock_sync));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_sync) |=> lflag);

    // R9
    fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 2'b01 && !lock_sync && !(wr_en && !addr)) |=> clk_sel == 2'b00);
endmodule

bind pllctl_top pllctl_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .clk_sel(clk_sel), .crit(crit), .lock_sync(lock_sync),
    .pll_on(ctrl.en), .lflag(flags.lock_flag)
);

// File: tb/test_pllctl_top.sv
module test_pllctl_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       lock_raw = 1'b0;
    logic [1:0] clk_sel;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pllctl_top i_pllctl_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lock_raw(lock_raw), .clk_sel(clk_sel), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R1 reg0", v, 8'h00);
        rd(1'b1, v); check("R1 reg1", v, 8'h00);
        check("R1 clk_sel", {6'b0, clk_sel}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_crit();
        logic [7:0] v;
        wr(1'b0, 8'h0C);
        rd(1'b0, v); check("R2 write while disabled", v, 8'h0C);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h04);
        rd(1'b0, v); check("R2 write while enabled ignored", v, 8'h0C);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_src();
        wr(1'b0, 8'h02);
        check("R3 setup rtc", {6'b0, clk_sel}, 8'h02);
        wr(1'b0, 8'h03);
        check("R3 reserved keeps", {6'b0, clk_sel}, 8'h02);
        wr(1'b0, 8'h01);
        check("R4 refused disabled", {6'b0, clk_sel}, 8'h02);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h01);
        check("R4 refused unlocked", {6'b0, clk_sel}, 8'h02);
    endtask

    task automatic t_sync_and_irq();
        logic [7:0] v;
        @(negedge clk) lock_raw = 1'b1;
        rd(1'b1, v); check("R5 status after one edge", {7'b0, v[5]}, 8'h00);
        rd(1'b1, v); check("R5 status after two edges", {7'b0, v[5]}, 8'h01);
        idle(2);
        rd(1'b1, v); check("R6 lock flag set", {7'b0, v[3]}, 8'h01);
        check("R8 irq masked", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h01);
        check("R4 pll accepted", {6'b0, clk_sel}, 8'h01);
        wr(1'b1, 8'h03);
        check("R8 irq lock enabled", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h0B);
        rd(1'b1, v); check("R7 clear lock flag", {7'b0, v[3]}, 8'h00);
        check("R8 irq after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_fallback();
        logic [7:0] v;
        @(negedge clk) lock_raw = 1'b0;
        idle(4);
        check("R9 fallback on unlock", {6'b0, clk_sel}, 8'h00);
        rd(1'b1, v); check("R6 unlock flag set", {7'b0, v[4]}, 8'h01);
        check("R8 irq unlock masked", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h05);
        check("R8 irq unlock enabled", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h15);
        rd(1'b1, v); check("R7 clear unlock flag", {7'b0, v[4]}, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        wr(1'b1, 8'h03);
        @(negedge clk) lock_raw = 1'b1;
        idle(4);
        @(negedge clk) lock_raw = 1'b0;
        idle(4);
        rd(1'b1, v); check("R7 setup flag still set", {7'b0, v[3]}, 8'h01);
        @(negedge clk) lock_raw = 1'b1;
        idle(2);
        wr_en = 1'b1; addr = 1'b1; wdata = 8'h0B;
        @(negedge clk);
        wr_en = 1'b0;
        rd(1'b1, v); check("R7 edge beats clear", {7'b0, v[3]}, 8'h01);
        wr(1'b1, 8'h0B);
        rd(1'b1, v); check("R7 later clear", {7'b0, v[3]}, 8'h00);
    endtask

    task automatic t_disable_and_enabled_writes();
        wr(1'b0, 8'h01);
        check("R9 setup pll", {6'b0, clk_sel}, 8'h01);
        wr(1'b0, 8'h02);
        check("R10 rtc while enabled", {6'b0, clk_sel}, 8'h02);
        wr(1'b0, 8'h00);
        check("R10 xtal while enabled", {6'b0, clk_sel}, 8'h00);
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h00);
        idle(1);
        check("R9 fallback on disable", {6'b0, clk_sel}, 8'h00);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_crit();
        t_src();
        t_sync_and_irq();
        t_fallback();
        t_collision();
        t_disable_and_enabled_writes();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule